// File: doc/BRIEF.md
# Real-Time Clock Prescaler with Seconds Match and 64 Hz Tick

This block runs on a 32.768 kHz clock. A 15-stage binary prescaler divides that clock down to a once-per-second edge. The block keeps a 32-bit seconds counter that advances on that edge, and a 32-bit alarm register that software can write.

It raises two single-cycle interrupt requests:
- A tick request, taken from the prescaler stage whose output runs at 64 Hz.
- A match request, raised one second after the seconds counter has equalled the alarm value.

Latching and clearing of both requests happen downstream. A standby input silences the tick but leaves timekeeping running.

Software reaches the two 32-bit values through a simple port:
- A write strobe with a one-bit select and a data word.
- A combinational read mux driven by its own one-bit select.

Loading the seconds value restarts the prescaler, so the first second after a load is a whole second.

Top module: `rtc_tick_match`

## Requirements
- R1: While reset is asserted and after its release, match_irq and tick_irq are low, and both readback selections return zero.
- R2: The prescaler counts 0 to 32767 and wraps to 0. The second edge is that wrap. The seconds value rises by one at each second edge, and 0xFFFFFFFF rolls over to 0.
- R3: tick_irq is a one-cycle pulse, seen in the cycle after the prescaler's low nine bits held 0x0FF (the rising edge of stage 9's output). It fires every 512 clocks, which is 64 pulses per second.
- R4: While standby is high at the clock edge that would produce a tick, no tick pulse appears. The prescaler and the seconds value keep running.
- R5: match_irq is a one-cycle pulse, seen in the cycle after a second edge. It fires only when the seconds value held just before that edge equals the alarm register.
- R6: A write with wr_sel=0 loads the seconds value and clears the prescaler. The next second edge follows 32768 clocks later. On the same edge the write overrides a second edge: there is no increment and no match pulse.
- R7: A write with wr_sel=1 loads the alarm register. A match comparison on that same edge still uses the alarm value held before the write.
- R8: rd_data returns the seconds value when rd_sel=0 and the alarm register when rd_sel=1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| standby | input | 1 | High silences the 64 Hz tick request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 seconds value, 1 alarm register |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 seconds value, 1 alarm register |
| rd_data | output | 32 | Read data |
| match_irq | output | 1 | One-cycle alarm match request |
| tick_irq | output | 1 | One-cycle 64 Hz tick request |

## Verification
Two kinds of register write can land on the very clock edge where the prescaler wraps into a new second.

- A seconds load: it must win over the increment and swallow a match that was due.
- An alarm load: it must leave that edge's comparison on the old alarm value.

The bench tracks the prescaler phase in its own model and issues each write exactly in the cycle when the wrap is due. It then judges the outcome from the readback value and from the number of match pulses seen, and checks every output against the model on every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RTC_DATA_W  = 32;
  localparam int RTC_STAGES  = 15;
  localparam int RTC_TICK_ST = 9;

  typedef enum logic {
    REG_SECS  = 1'b0,
    REG_ALARM = 1'b1
  } rtc_reg_e;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int STAGES     = 15,
  parameter int TICK_STAGE = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              standby,
  output logic [STAGES-1:0] presc_q,
  output logic              sec_stb,
  output logic              tick_stb
);
  localparam logic [STAGES-1:0]     PRESC_FULL = '1;
  localparam logic [TICK_STAGE-1:0] TICK_PRE   = {1'b0, {(TICK_STAGE-1){1'b1}}};

  logic [STAGES-1:0] presc_d;

  always_comb begin
    presc_d  = clear ? '0 : presc_q + 1'b1;
    sec_stb  = !clear && (presc_q == PRESC_FULL);
    tick_stb = !clear && !standby && (presc_q[TICK_STAGE-1:0] == TICK_PRE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_stb,
  input  logic              wr_secs,
  input  logic              wr_alarm,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] secs_q,
  output logic [DATA_W-1:0] alarm_q,
  output logic              match_q
);
  logic [DATA_W-1:0] secs_d;
  logic [DATA_W-1:0] alarm_d;
  logic              match_d;

  always_comb begin
    secs_d  = secs_q;
    alarm_d = alarm_q;
    if (wr_secs)      secs_d = wr_data;
    else if (sec_stb) secs_d = secs_q + 1'b1;
    if (wr_alarm)     alarm_d = wr_data;
    match_d = sec_stb && (secs_q == alarm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q  <= '0;
      alarm_q <= '0;
      match_q <= 1'b0;
    end else begin
      secs_q  <= secs_d;
      alarm_q <= alarm_d;
      match_q <= match_d;
    end
  end
endmodule

// File: rtl/rtc_tick_match.sv
module rtc_tick_match #(
  parameter int STAGES     = rtc_pkg::RTC_STAGES,
  parameter int TICK_STAGE = rtc_pkg::RTC_TICK_ST,
  parameter int DATA_W     = rtc_pkg::RTC_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              match_irq,
  output logic              tick_irq
);
  import rtc_pkg::*;

  logic              rst_i;
  logic              wr_secs;
  logic              wr_alarm;
  logic [STAGES-1:0] presc_q;
  logic              sec_stb;
  logic              tick_stb;
  logic [DATA_W-1:0] secs_q;
  logic [DATA_W-1:0] alarm_q;

  always_comb begin
    wr_secs  = wr_en && (rtc_reg_e'(wr_sel) == REG_SECS);
    wr_alarm = wr_en && (rtc_reg_e'(wr_sel) == REG_ALARM);
    rd_data  = (rtc_reg_e'(rd_sel) == REG_ALARM) ? alarm_q : secs_q;
  end

  rtc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  rtc_divider #(
    .STAGES     (STAGES),
    .TICK_STAGE (TICK_STAGE)
  ) u_divider (
    .clk      (clk),
    .rst_n    (rst_i),
    .clear    (wr_secs),
    .standby  (standby),
    .presc_q  (presc_q),
    .sec_stb  (sec_stb),
    .tick_stb (tick_stb)
  );

  rtc_seconds #(
    .DATA_W (DATA_W)
  ) u_seconds (
    .clk      (clk),
    .rst_n    (rst_i),
    .sec_stb  (sec_stb),
    .wr_secs  (wr_secs),
    .wr_alarm (wr_alarm),
    .wr_data  (wr_data),
    .secs_q   (secs_q),
    .alarm_q  (alarm_q),
    .match_q  (match_irq)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) tick_irq <= 1'b0;
    else        tick_irq <= tick_stb;
  end
endmodule

// File: rtl/rtc_tick_match_chk.sv
module rtc_tick_match_chk #(
  parameter int STAGES     = 15,
  parameter int TICK_STAGE = 9,
  parameter int DATA_W     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [STAGES-1:0] presc_q,
  input logic [DATA_W-1:0] secs_q,
  input logic [DATA_W-1:0] alarm_q,
  input logic              match_irq,
  input logic              tick_irq
);
  localparam logic [STAGES-1:0]     PRESC_FULL = '1;
  localparam logic [TICK_STAGE-1:0] TICK_POST  = {1'b1, {(TICK_STAGE-1){1'b0}}};

  a_r2_secs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && !wr_sel) && (presc_q != PRESC_FULL)) |=> $stable(secs_q));

  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |=> !tick_irq);

  a_r3_tick_phase: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> (presc_q[TICK_STAGE-1:0] == TICK_POST));

  a_r4_no_tick_standby: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> !$past(standby));

  a_r5_match_single: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |=> !match_irq);

  a_r5_match_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> ((presc_q == '0) && (secs_q == $past(secs_q) + 1'b1)));

  a_r6_secs_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> ((secs_q == $past(wr_data)) && (presc_q == '0) && !match_irq));

  a_r7_alarm_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (alarm_q == $past(wr_data)));
endmodule

bind rtc_tick_match rtc_tick_match_chk #(
  .STAGES     (STAGES),
  .TICK_STAGE (TICK_STAGE),
  .DATA_W     (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_i),
  .standby   (standby),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .presc_q   (presc_q),
  .secs_q    (secs_q),
  .alarm_q   (alarm_q),
  .match_irq (match_irq),
  .tick_irq  (tick_irq)
);

// File: tb/rtc_tick_match_bench.sv
module rtc_tick_match_bench;
  localparam int PERIOD = 32768;

  logic        clk;
  logic        rst_n;
  logic        standby;
  logic        wr_en;
  logic        wr_sel;
  logic [31:0] wr_data;
  logic        rd_sel;
  logic [31:0] rd_data;
  logic        match_irq;
  logic        tick_irq;

  int n_checks = 0;
  int n_errors = 0;
  int cyc      = 0;
  int tick_seen = 0;
  int match_seen = 0;

  // reference model state
  int          ref_presc;
  int          ref_rel;
  logic [31:0] ref_secs;
  logic [31:0] ref_alarm;
  logic        ref_mirq;
  logic        ref_tirq;

  rtc_tick_match u_rtc_tick_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby   (standby),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .match_irq (match_irq),
    .tick_irq  (tick_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // behavioural reference: counts clocks, wraps at one second
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_presc <= 0; ref_rel <= 0; ref_secs <= '0; ref_alarm <= '0;
      ref_mirq <= 1'b0; ref_tirq <= 1'b0;
    end else if (ref_rel < 2) begin
      ref_rel <= ref_rel + 1;
    end else begin
      bit load_t, second;
      load_t = wr_en && !wr_sel;
      second = !load_t && (ref_presc == PERIOD - 1);
      ref_mirq <= second && (ref_secs == ref_alarm);
      ref_tirq <= !load_t && !standby && ((ref_presc % 512) == 255);
      if (load_t) begin
        ref_secs <= wr_data; ref_presc <= 0;
      end else if (second) begin
        ref_secs <= ref_secs + 32'd1; ref_presc <= 0;
      end else begin
        ref_presc <= ref_presc + 1;
      end
      if (wr_en && wr_sel) ref_alarm <= wr_data;
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    logic [31:0] exp_rd;
    exp_rd = rd_sel ? ref_alarm : ref_secs;
    check(rd_data === exp_rd, "R8 rd_data vs model", rd_data, exp_rd);
    check(match_irq === ref_mirq, "R5 match_irq vs model", {31'd0, match_irq}, {31'd0, ref_mirq});
    check(tick_irq === ref_tirq, "R3 tick_irq vs model", {31'd0, tick_irq}, {31'd0, ref_tirq});
    if (tick_irq) tick_seen++;
    if (match_irq) match_seen++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 198000) begin
      n_errors++;
      $display("FAIL watchdog expired got %0d exp finish", cyc);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
    end
  endtask

  task automatic write_reg(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic wait_wrap_due();
    while (ref_presc != PERIOD - 1) step(1);
  endtask

  task automatic read_chk(input logic sel, input logic [31:0] exp, input string tag);
    rd_sel = sel; #1;
    check(rd_data === exp, tag, rd_data, exp);
  endtask

  initial begin
    rst_n = 1'b0; standby = 1'b0; wr_en = 1'b0; wr_sel = 1'b0;
    wr_data = '0; rd_sel = 1'b0;
    step(4);
    check(match_irq === 1'b0 && tick_irq === 1'b0, "R1 outputs low in reset",
          {30'd0, match_irq, tick_irq}, 32'd0);
    rst_n = 1'b1;
    step(3);
    read_chk(1'b1, 32'd0, "R1 alarm zero after reset");
    read_chk(1'b0, 32'd0, "R1 seconds zero after reset");

    // one full second from a seconds load
    write_reg(1'b1, 32'd6);
    write_reg(1'b0, 32'd5);
    tick_seen = 0;
    step(PERIOD - 1);
    read_chk(1'b0, 32'd5, "R6 no advance before a full second");
    check(tick_seen == 64, "R3 ticks per second", tick_seen, 64);
    step(1);
    read_chk(1'b0, 32'd6, "R2 advance after 32768 clocks");

    // standby second; alarm 6 equals seconds 6
    standby = 1'b1; tick_seen = 0; match_seen = 0;
    step(PERIOD + 1);
    check(tick_seen == 0, "R4 no tick in standby", tick_seen, 0);
    read_chk(1'b0, 32'd7, "R4 seconds run in standby");
    check(match_seen == 1, "R5 match one second after equality", match_seen, 1);
    standby = 1'b0;

    // seconds load on the wrap edge suppresses a due match
    write_reg(1'b1, 32'd7);
    wait_wrap_due();
    match_seen = 0;
    write_reg(1'b0, 32'd100);
    step(1);
    check(match_seen == 0, "R6 load beats second edge, no match", match_seen, 0);
    read_chk(1'b0, 32'd100, "R6 load beats increment");

    // alarm load on the wrap edge: compare uses old alarm
    write_reg(1'b1, 32'd100);
    wait_wrap_due();
    match_seen = 0;
    write_reg(1'b1, 32'd200);
    step(1);
    check(match_seen == 1, "R7 edge compares old alarm", match_seen, 1);
    read_chk(1'b1, 32'd200, "R7 alarm holds new value");
    read_chk(1'b0, 32'd101, "R8 seconds readback");

    // rollover with match at all ones
    write_reg(1'b1, 32'hFFFF_FFFF);
    write_reg(1'b0, 32'hFFFF_FFFF);
    match_seen = 0;
    step(PERIOD + 1);
    read_chk(1'b0, 32'd0, "R2 rollover to zero");
    check(match_seen == 1, "R5 match at rollover", match_seen, 1);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule